// File: doc/BRIEF.md
# Carry Select Adder with Excess-One Converter

This block is a purely combinational 16-bit adder built as a carry select structure. The operand width is cut into five slices of 2, 2, 3, 4 and 5 bits, from least to most significant. The lowest slice is a plain ripple-carry adder fed by the external carry in.

Every higher slice runs a single ripple adder whose carry in is tied to zero. The result for a carry in of one is not produced by a second adder. An increment circuit (a binary-to-excess-one converter) adds one to the zero-carry result, carry included. The carry leaving the slice below then picks one of the two candidates through a multiplexer.

The block drops into any datapath that needs a plain add with carry in and carry out. It has no clock and no state, so the result is valid once the inputs have settled.

Top module: `carry_select_adder`

## Requirements
- R1: For every input combination, the 17-bit value {carry_out, sum_out} equals op_a + op_b + carry_in, computed as unsigned integers.
- R2: A carry produced at bit 0 must travel through every slice boundary. For op_a = 0xFFFF, op_b = 0x0000 and carry_in = 1, the outputs are sum_out = 0x0000 and carry_out = 1.
- R3: With op_b = 0 and carry_in = 0, sum_out equals op_a and carry_out is 0.
- R4: In each upper slice, the converter output equals its (width+1)-bit input {zero-carry carry out, zero-carry sum} plus one, modulo 2^(width+1). At the ports, a value op_a = 2^k − 1 with op_b = 0 and carry_in = 1 gives sum_out = 2^k for every slice boundary k in {2, 4, 7, 11}.
- R5: Each upper slice outputs its converter result when the carry from the slice below is 1, and its zero-carry ripple result when that carry is 0.
- R6: carry_out is 1 exactly when op_a + op_b + carry_in is 65536 or more.
- R7: The lowest slice (bits 1:0) is a ripple adder driven by carry_in. Its sum bits and the carry it passes upward equal the low two bits and bit 2 of op_a[1:0] + op_b[1:0] + carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bench goes after the slice boundaries at bits 2, 4, 7 and 11. There it drives all-ones runs plus a carry in, so each converter must increment across its whole slice. A converter that dropped the carry bit, or a select wired to the wrong neighbour, would show a zero gap or a stray one just above a boundary. It runs all 32 low-slice patterns, with the upper bits of op_a set to ones, so that an error in the lowest ripple adder or in its carry spreads into the upper sum bits. It also covers the all-ones and half-range overflow cases, where an inverted or missing top carry flips carry_out, and adds random operands for general arithmetic faults.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
// Package: slice layout of the carry select adder.
// Assumes the slice widths sum to the operand width used by the top.
package csa_pkg;
    localparam int NUM_GROUPS = 5;

    // Width of slice g, least significant slice first.
    function automatic int grp_w(input int g);
        case (g)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // Bit position of the lowest bit of slice g.
    function automatic int grp_lsb(input int g);
        int pos;
        pos = 0;
        for (int i = 0; i < g; i++) pos += grp_w(i);
        return pos;
    endfunction

    localparam int TOTAL_W = grp_lsb(NUM_GROUPS);
endpackage

// File: rtl/rca_unit.sv
`timescale 1ns/1ps
// Module: rca_unit
// Ripple-carry adder of W bits built from full-adder equations.
// Assumes W >= 1; purely combinational.
module rca_unit #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic rip;

    // Ripple the carry bit by bit through full-adder equations.
    always_comb begin
        rip = cin;
        for (int i = 0; i < W; i++) begin
            s[i] = a[i] ^ b[i] ^ rip;
            rip  = (a[i] & b[i]) | (rip & (a[i] ^ b[i]));
        end
        cout = rip;
    end
endmodule

// File: rtl/excess_one_conv.sv
`timescale 1ns/1ps
// Module: excess_one_conv
// Adds one to a W-bit value: bit 0 is inverted, and every higher bit
// toggles when all bits below it are one. Assumes W >= 2; combinational.
module excess_one_conv #(
    parameter int W = 3
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic all_low;

    // Toggle each bit when every lower bit is one.
    always_comb begin
        all_low = 1'b1;
        for (int i = 0; i < W; i++) begin
            y[i]    = x[i] ^ all_low;
            all_low = all_low & x[i];
        end
    end

    // Check the toggle network against arithmetic increment.
    always_comb begin
        // R4
        inc_exact_chk: assert (y == x + {{(W-1){1'b0}}, 1'b1})
            else $error("R4 converter: in=%h out=%h", x, y);
    end
endmodule

// File: rtl/csel_group.sv
`timescale 1ns/1ps
// Module: csel_group
// One upper slice: a ripple adder with carry in 0, an excess-one
// converter for the carry-in-1 result, and a result multiplexer steered
// by the carry from the slice below. Assumes W >= 1; combinational.
module csel_group #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_c,
    output logic [W-1:0] s,
    output logic         cout
);
    localparam int XW = W + 1;

    logic [W-1:0]  s_zero;
    logic          c_zero;
    logic [XW-1:0] r_one;

    rca_unit #(.W(W)) u_rca (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .s    (s_zero),
        .cout (c_zero)
    );

    excess_one_conv #(.W(XW)) u_inc (
        .x ({c_zero, s_zero}),
        .y (r_one)
    );

    // Pick the candidate that matches the incoming carry.
    always_comb begin
        if (sel_c) {cout, s} = r_one;
        else       {cout, s} = {c_zero, s_zero};
    end

    // Check the selected result against the slice arithmetic.
    always_comb begin
        // R5
        sel_one_chk: assert (!sel_c ||
            ({cout, s} == {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1}))
            else $error("R5 slice with carry 1: a=%h b=%h got=%h", a, b, {cout, s});
        // R5
        sel_zero_chk: assert (sel_c || ({cout, s} == {1'b0, a} + {1'b0, b}))
            else $error("R5 slice with carry 0: a=%h b=%h got=%h", a, b, {cout, s});
    end
endmodule

// File: rtl/carry_select_adder.sv
`timescale 1ns/1ps
// Module: carry_select_adder
// 16-bit carry select adder. Slice 0 is a ripple adder fed by carry_in.
// Each higher slice is a csel_group steered by the carry of the slice
// below. Assumes the slice table in csa_pkg; combinational, no reset.
module carry_select_adder
    import csa_pkg::*;
(
    input  logic [TOTAL_W-1:0] op_a,
    input  logic [TOTAL_W-1:0] op_b,
    input  logic               carry_in,
    output logic [TOTAL_W-1:0] sum_out,
    output logic               carry_out
);
    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
            localparam int GW  = grp_w(g);
            localparam int LSB = grp_lsb(g);
            logic c_out;
            if (g == 0) begin : g_low
                rca_unit #(.W(GW)) u_low (
                    .a    (op_a[LSB +: GW]),
                    .b    (op_b[LSB +: GW]),
                    .cin  (carry_in),
                    .s    (sum_out[LSB +: GW]),
                    .cout (c_out)
                );
            end else begin : g_up
                csel_group #(.W(GW)) u_sel (
                    .a     (op_a[LSB +: GW]),
                    .b     (op_b[LSB +: GW]),
                    .sel_c (gen_grp[g-1].c_out),
                    .s     (sum_out[LSB +: GW]),
                    .cout  (c_out)
                );
            end
        end
    endgenerate

    assign carry_out = gen_grp[NUM_GROUPS-1].c_out;

    // Check the whole adder and the lowest slice against arithmetic.
    always_comb begin
        // R1
        sum_exact_chk: assert ({carry_out, sum_out} ==
            {1'b0, op_a} + {1'b0, op_b} + {{TOTAL_W{1'b0}}, carry_in})
            else $error("R1 adder: a=%h b=%h ci=%b got=%h", op_a, op_b, carry_in,
                        {carry_out, sum_out});
        // R7
        low_carry_chk: assert (gen_grp[0].c_out ==
            (({1'b0, op_a[1:0]} + {1'b0, op_b[1:0]} + {2'b00, carry_in}) >> 2))
            else $error("R7 low slice carry mismatch");
    end
endmodule

// File: tb/test_carry_select_adder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies operands at the falling edge and
// queues the expected sum. The monitor pops the queue at the rising edge
// and compares it with the outputs.
module test_carry_select_adder;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [16:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    carry_select_adder i_carry_select_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // Drive one vector and queue its expected 17-bit result.
    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic ci, input string tag);
        item_t it;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = ci;
        it.exp   = {1'b0, a} + {1'b0, b} + {16'd0, ci};
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each queued item with the outputs.
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({carry_out, sum_out} !== it.exp) begin
                    errors++;
                    $display("FAIL %s: a=%h b=%h ci=%b actual=%h expected=%h",
                             it.tag, op_a, op_b, carry_in,
                             {carry_out, sum_out}, it.exp);
                end
            end
        end
    end

    // Stimulus.
    initial begin
        // R3: zero operands, then add of zero leaves op_a unchanged
        apply(16'h0000, 16'h0000, 1'b0, "R3 all zero");
        apply(16'h1234, 16'h0000, 1'b0, "R3 identity");
        apply(16'hBEEF, 16'h0000, 1'b0, "R3 identity");
        // R7: all low-slice patterns with ones above to expose carry spread
        for (int p = 0; p < 32; p++)
            apply({14'h3FFF, p[1:0]}, {14'h0000, p[3:2]}, p[4], "R7 low slice");
        // R2: carry from bit 0 through every slice
        apply(16'hFFFF, 16'h0000, 1'b1, "R2 full propagate");
        apply(16'h0000, 16'hFFFF, 1'b1, "R2 full propagate");
        // R4: increment across each slice boundary
        apply(16'h0003, 16'h0000, 1'b1, "R4 boundary 2");
        apply(16'h000F, 16'h0000, 1'b1, "R4 boundary 4");
        apply(16'h007F, 16'h0000, 1'b1, "R4 boundary 7");
        apply(16'h07FF, 16'h0000, 1'b1, "R4 boundary 11");
        // R5: upper slices with and without an incoming carry
        apply(16'h0FF3, 16'h0000, 1'b1, "R5 select carry 1");
        apply(16'h0FF3, 16'h0000, 1'b0, "R5 select carry 0");
        apply(16'h5552, 16'h2AA1, 1'b1, "R5 select mixed");
        // R6: overflow corners
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 max sum");
        apply(16'hFFFF, 16'hFFFF, 1'b0, "R6 max sum no ci");
        apply(16'h8000, 16'h8000, 1'b0, "R6 half range");
        apply(16'h8000, 16'h7FFF, 1'b0, "R6 just below");
        // R1: random operands
        for (int n = 0; n < 300; n++)
            apply(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule